// File: doc/BRIEF.md
# Masked register polling unit

This block sits beside a register bus bridge. It holds back each byte access of a transfer until a chosen register shows an expected pattern. For each byte, the bridge hands it a polling address, a bit mask and an expected value, and pulses `start`. The unit then reads the polled register over the internal bus again and again. It stops when the bits selected by the mask agree with the same bits of the expected value, and it reports `hit`. The bridge then performs the pending byte access. If that never happens in time, the unit reports a miss and the bridge abandons the access.

A cycle-count timeout is held in a register that the bridge loads. A value of zero means the unit waits without limit. The loaded value is copied into a working copy when a new command begins, so a reload affects only later commands. Once one byte of a command has timed out, every later byte of the same command is refused at once, without touching the bus, until the next command begins. The bus read port is shared by simple handoff: the unit drives it only while `busy` is high.

Top module: `poll_unit`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are low, and the working timeout is zero.
- R2: A `start` accepted while idle, with no earlier timeout in the current command, raises `rd_req` for exactly one cycle with `rd_addr` equal to the `poll_addr` captured at `start`. Each later retry reads the same address, again with a one-cycle `rd_req`.
- R3: A returned word matches when `(rd_data & mask) == (value & mask)`. Bits outside the mask are ignored, so a mask of zero always matches. On a match, `done` rises with `hit`=1 in the cycle after the one in which `rd_valid` was sampled.
- R4: A mismatching word causes a new read to be issued in the next cycle. Polling continues until a match or a timeout.
- R5: A working timeout of zero never ends a poll. Zero is the value after reset.
- R6: The elapsed count is 0 in the first cycle after `start` and rises by one each following cycle. If the count is at least a non-zero working timeout when a mismatching word is sampled, the poll ends: `done` rises in the next cycle with `hit`=0. A matching word always wins.
- R7: After a miss, every `start` in the same command gives `done` with `hit`=0 in the next cycle, and no bus read is made. A `cmd_begin` pulse clears this condition.
- R8: `cfg_load` writes `cfg_delay` into the held timeout, but the working timeout takes that value only at the next `cmd_begin`. A load made during a poll does not change that poll or any later poll of the same command.
- R9: `busy` is high from the cycle after `start` is accepted through the `done` cycle. `start` is accepted only while `busy` is low.
- R10: `done` is a single-cycle pulse. `hit` is meaningful only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| cfg_load | input | 1 | Write `cfg_delay` into the held timeout |
| cfg_delay | input | TW | Timeout value in clock cycles, 0 = no limit |
| cmd_begin | input | 1 | A new command starts: copy the held timeout into the working one and clear the timed-out condition |
| start | input | 1 | Begin the poll for one byte |
| poll_addr | input | AW | Address of the register to watch |
| poll_mask | input | DW | Bits that take part in the comparison |
| poll_value | input | DW | Expected value of the masked bits |
| busy | output | 1 | Poll in progress; the unit owns the read port |
| done | output | 1 | One-cycle end-of-poll pulse |
| hit | output | 1 | With `done`: 1 = perform the access, 0 = abandon it |
| rd_req | output | 1 | Bus read request |
| rd_addr | output | AW | Bus read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DW | Read data |

## Verification
The bench keeps AW=16 and DW=8 but builds the unit with an 8-bit timeout (TW=8). This puts the largest possible timeout, 255 cycles, within a run of about a hundred retries, so the upper end of the counter range is exercised as well as timeouts of 1 and a few cycles. The bus responder in the bench answers one cycle after each request. It returns a non-matching word until a scripted number of reads has passed, which places the match before, on or after the timeout boundary.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_REQ  = 2'd1,
    PS_WAIT = 2'd2,
    PS_DONE = 2'd3
  } poll_state_e;

endpackage

// File: rtl/poll_rst_sync.sv
module poll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/poll_match.sv
module poll_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] value,
  output logic          equal
);
  logic [DW-1:0] diff;

  // Only bits selected by the mask may disagree-check; others are don't-care.
  always_comb begin
    diff  = (word & mask) ^ (value & mask);
    equal = (diff == '0);
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_delay,
  input  logic          cmd_begin,
  input  logic          clr,
  input  logic          run,
  input  logic          set_miss,
  output logic          expired,
  output logic          missed,
  output logic [TW-1:0] active
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] held_q, held_d;
  logic [TW-1:0] active_q, active_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          miss_q, miss_d;
  logic          held_en, active_en, cnt_en, miss_en;

  always_comb begin
    held_en   = cfg_load;
    held_d    = cfg_delay;
    active_en = cmd_begin;
    active_d  = held_q;
    cnt_en    = clr | (run & (cnt_q != CNT_MAX));
    cnt_d     = clr ? '0 : cnt_q + 1'b1;
    miss_en   = cmd_begin | set_miss;
    miss_d    = !cmd_begin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      active_q <= '0;
      cnt_q    <= '0;
      miss_q   <= 1'b0;
    end else begin
      if (held_en)   held_q   <= held_d;
      if (active_en) active_q <= active_d;
      if (cnt_en)    cnt_q    <= cnt_d;
      if (miss_en)   miss_q   <= miss_d;
    end
  end

  assign expired = (active_q != '0) && (cnt_q >= active_q);
  assign missed  = miss_q;
  assign active  = active_q;

  // R8: the working copy moves only when a command begins
  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_begin |=> $stable(active_q));

  // R5: a zero working timeout never reports expiry
  assert_zero_no_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> !expired);
endmodule

// File: rtl/poll_unit.sv
module poll_unit #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_delay,
  input  logic          cmd_begin,
  input  logic          start,
  input  logic [AW-1:0] poll_addr,
  input  logic [DW-1:0] poll_mask,
  input  logic [DW-1:0] poll_value,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data
);
  import poll_pkg::*;

  logic          rst_i_n;
  poll_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q, val_q;
  logic          hit_q, hit_d;
  logic          cap_en;
  logic          word_eq;
  logic          expired, missed, set_miss;
  logic          miss_now;
  logic [TW-1:0] active_to;

  poll_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  poll_match #(.DW(DW)) u_match (
    .word  (rd_data),
    .mask  (mask_q),
    .value (val_q),
    .equal (word_eq)
  );

  poll_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_load  (cfg_load),
    .cfg_delay (cfg_delay),
    .cmd_begin (cmd_begin),
    .clr       (cap_en),
    .run       ((state_q == PS_REQ) || (state_q == PS_WAIT)),
    .set_miss  (set_miss),
    .expired   (expired),
    .missed    (missed),
    .active    (active_to)
  );

  // A command boundary in the same cycle as start clears the timed-out state.
  assign miss_now = missed & ~cmd_begin;

  always_comb begin
    state_d  = state_q;
    hit_d    = hit_q;
    cap_en   = 1'b0;
    set_miss = 1'b0;
    unique case (state_q)
      PS_IDLE: if (start) begin
        cap_en = 1'b1;
        if (miss_now) begin
          state_d = PS_DONE;
          hit_d   = 1'b0;
        end else begin
          state_d = PS_REQ;
        end
      end
      PS_REQ:  state_d = PS_WAIT;
      PS_WAIT: if (rd_valid) begin
        if (word_eq) begin
          state_d = PS_DONE;
          hit_d   = 1'b1;
        end else if (expired) begin
          state_d  = PS_DONE;
          hit_d    = 1'b0;
          set_miss = 1'b1;
        end else begin
          state_d = PS_REQ;
        end
      end
      PS_DONE: state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= PS_IDLE;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      val_q   <= '0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
      if (cap_en) begin
        addr_q <= poll_addr;
        mask_q <= poll_mask;
        val_q  <= poll_value;
      end
    end
  end

  assign busy    = (state_q != PS_IDLE);
  assign done    = (state_q == PS_DONE);
  assign hit     = hit_q;
  assign rd_req  = (state_q == PS_REQ);
  assign rd_addr = addr_q;

  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> !rd_req);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);

  assert_hit_from_match_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && hit) |-> $past(rd_valid && word_eq));

  assert_miss_needs_limit_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !hit) |-> (active_to != '0));

  assert_skip_after_miss_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && start && missed && !cmd_begin) |=> (done && !hit && !rd_req));

  assert_busy_on_start_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && start) |=> busy);
endmodule

// File: tb/sim_poll_unit.sv
`timescale 1ns/1ps
module sim_poll_unit;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [TW-1:0] cfg_delay = '0;
  logic          cmd_begin = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [DW-1:0] poll_mask = '0;
  logic [DW-1:0] poll_value = '0;
  logic          busy, done, hit, rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;

  always #2.5 clk = ~clk;

  poll_unit #(.AW(AW), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_delay(cfg_delay),
    .cmd_begin(cmd_begin), .start(start), .poll_addr(poll_addr),
    .poll_mask(poll_mask), .poll_value(poll_value), .busy(busy), .done(done),
    .hit(hit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  int  m_held = 0;
  int  m_active = 0;
  bit  m_missed = 0;
  bit  m_run = 0;
  int  m_e = 0;
  int  m_done_cyc = -1;
  bit  m_hit = 0;
  int  m_addr = 0;
  string m_tag = "";
  // responder
  int  rsp_after = 0;
  logic [DW-1:0] rsp_good = '0, rsp_bad = '0;
  int  reads = 0;
  bit  pend = 0;
  bit  saw_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit e_done = m_run && (cyc == m_done_cyc);
      automatic bit e_busy = m_run && (cyc >= m_e) && (cyc <= m_done_cyc);
      chk(done == e_done, {m_tag, "/R10 done"}, int'(done), int'(e_done));
      chk(busy == e_busy, "R9 busy", int'(busy), int'(e_busy));
      if (e_done) begin
        chk(hit == m_hit, {m_tag, " hit"}, int'(hit), int'(m_hit));
        saw_done = 1;
      end
      if (rd_req) chk(int'(rd_addr) == m_addr, "R2 rd_addr", int'(rd_addr), m_addr);
    end
    if (pend) begin
      rd_valid = 1'b1;
      rd_data  = (reads >= rsp_after) ? rsp_good : rsp_bad;
      reads++;
      pend = 0;
    end else begin
      rd_valid = 1'b0;
    end
    if (rd_req) pend = 1;
  end

  task automatic load(input int v);
    @(negedge clk);
    cfg_load = 1; cfg_delay = TW'(v); m_held = v;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic cmd();
    @(negedge clk);
    cmd_begin = 1; m_active = m_held; m_missed = 0;
    @(negedge clk);
    cmd_begin = 0;
  endtask

  // after: number of mismatching reads before the register matches
  task automatic poll(input int a, input int mk, input int v, input int after,
                      input int mid_load, input string tag);
    automatic int r;
    automatic int n_to;
    automatic bit skip = m_missed;
    @(negedge clk);
    n_to = (m_active == 0) ? 1000000 : m_active / 2;
    if (skip) begin
      r = 0; m_hit = 0;
    end else if (after <= n_to) begin
      r = after; m_hit = 1;
    end else begin
      r = n_to; m_hit = 0; m_missed = 1;
    end
    m_e = cyc + 1;
    m_done_cyc = skip ? m_e : m_e + 2*r + 2;
    m_addr = a; m_tag = tag; m_run = 1;
    reads = 0; saw_done = 0; rsp_after = after;
    rsp_good = DW'((v & mk) | (~mk & 8'h5A));
    rsp_bad  = DW'(rsp_good ^ (mk & -mk));
    if (mk == 0) rsp_bad = ~rsp_good;
    start = 1; poll_addr = AW'(a); poll_mask = DW'(mk); poll_value = DW'(v);
    @(negedge clk);
    start = 0;
    if (mid_load >= 0) begin
      cfg_load = 1; cfg_delay = TW'(mid_load); m_held = mid_load;
      @(negedge clk);
      cfg_load = 0;
    end
    while (cyc <= m_done_cyc) @(negedge clk);
    m_run = 0;
    chk(saw_done, {tag, " done seen"}, int'(saw_done), 1);
    chk(reads == (skip ? 0 : r + 1), {tag, " read count"}, reads, skip ? 0 : r + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !rd_req, "R1 reset outputs", int'({busy, done, rd_req}), 0);
    cmd();
    poll(16'h1234, 8'hFF, 8'hA5, 0, -1, "R3 full mask");
    poll(16'h0042, 8'h0F, 8'h03, 0, -1, "R3 partial mask");
    poll(16'hBEEF, 8'h00, 8'hFF, 0, -1, "R3 zero mask");
    poll(16'h0100, 8'h81, 8'h80, 3, -1, "R4 retries");
    poll(16'h0101, 8'hFF, 8'h11, 40, -1, "R5 unlimited");
    poll(16'h0200, 8'hF0, 8'h70, 5, 2, "R8 load mid poll");
    poll(16'h0201, 8'hF0, 8'h70, 5, -1, "R8 same command");
    cmd();
    poll(16'h0300, 8'hFF, 8'h33, 5, -1, "R8 next command");
    poll(16'h0301, 8'hFF, 8'h33, 0, -1, "R7 skip after miss");
    poll(16'h0302, 8'hFF, 8'h33, 0, -1, "R7 skip again");
    load(6);
    cmd();
    poll(16'h0400, 8'h3C, 8'h14, 0, -1, "R7 cleared");
    poll(16'h0401, 8'h3C, 8'h14, 3, -1, "R6 match at limit");
    poll(16'h0402, 8'h3C, 8'h14, 10, -1, "R6 timeout");
    load(1);
    cmd();
    poll(16'h0500, 8'hFF, 8'h01, 0, -1, "R6 delay 1 match wins");
    poll(16'h0501, 8'hFF, 8'h01, 1, -1, "R6 delay 1 timeout");
    load(255);
    cmd();
    poll(16'h0600, 8'hFF, 8'hC3, 200, -1, "R6 max delay");
    load(0);
    cmd();
    poll(16'h0700, 8'hFF, 8'h99, 2, -1, "R5 back to zero");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule